// File: doc/BRIEF.md
# Framed DDR Sample Deframer

This block sits behind the data port of an RF transceiver that carries two receive and two transmit channels. On the receive side it takes a source-synchronous sample stream, given per clock cycle as a pair of words: one captured on the rising edge and one on the falling edge. It also takes the FRAME strobe sampled on the same two edges. The block keeps a running history of FRAME. When that history shows a complete frame pattern, it emits the four 12-bit samples I0, Q0, I1, Q1 together with a one-cycle valid strobe. The transmit side runs the same framing in reverse. It takes in one set of four samples per frame and drives out the edge data pairs and the FRAME strobe.

Two bus modes are selected by `narrow_mode`, which is held static outside reset. In wide mode each edge carries a whole 12-bit sample, so a frame lasts two clock cycles (four edges). In narrow mode each edge carries 6 bits, so a sample spans both edges of one cycle and a frame lasts four clock cycles (eight edges). The two data ports are never swapped or reordered beyond what is listed below.

Top module: `framed_ddr_deframer`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `rx_locked`, `rx_frame_err`, `tx_frame_rise`, `tx_frame_fall`, `tx_rise_data` and `tx_fall_data` are 0 and `tx_pull` is 1.
- R2: Narrow mode: each cycle's sample is `{rx_rise_data[5:0], rx_fall_data[5:0]}`, so the rising edge carries the upper half. A frame is recognised when the last eight FRAME edges, oldest first, read 1111_0000. Within each cycle the rising edge comes before the falling edge.
- R3: Wide mode: each cycle carries two samples, the rising-edge word first. A frame is recognised when the last four FRAME edges, oldest first, read 1100.
- R4: The frame's samples appear in arrival order: first on `rx_i0`, then `rx_q0`, `rx_i1` and `rx_q1`.
- R5: `rx_valid` is a single-cycle pulse. It appears on the clock edge that captures the final edge pair of a recognised frame. All four sample outputs change together on that edge and hold at every other time.
- R6: A recognised frame sets `rx_locked`. While locked, a frame boundary without the pattern sets `rx_frame_err` and clears `rx_locked`. In that case no `rx_valid` is given until a pattern is seen again.
- R7: `rx_frame_err` stays set until reset. Activity before the first lock never sets it.
- R8: `tx_pull` is high for exactly one cycle per frame. The four `tx_*` sample inputs are captured on that cycle's clock edge, and the frame's first edge pair leaves on the same edge.
- R9: Narrow transmit: the sample for I0, Q0, I1 and Q1 is sent in turn, one per cycle. Its upper 6 bits go on `tx_rise_data[5:0]` and its lower 6 bits on `tx_fall_data[5:0]`, with bits 11:6 of both driven 0. The FRAME edges read 1111_0000.
- R10: Wide transmit: the first cycle carries I0 on the rising edge and Q0 on the falling edge. The second cycle carries I1 and Q1 the same way. The FRAME edges read 1100.
- R11: In narrow mode, bits 11:6 of `rx_rise_data` and `rx_fall_data` have no effect on the received samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 1 = 6-bit double-edge bus, 0 = 12-bit bus |
| rx_rise_data | input | 12 | Receive word from rising edge |
| rx_fall_data | input | 12 | Receive word from falling edge |
| rx_frame_rise | input | 1 | FRAME sampled on rising edge |
| rx_frame_fall | input | 1 | FRAME sampled on falling edge |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| rx_i0 | output | 12 | Channel 0 I sample |
| rx_q0 | output | 12 | Channel 0 Q sample |
| rx_i1 | output | 12 | Channel 1 I sample |
| rx_q1 | output | 12 | Channel 1 Q sample |
| rx_locked | output | 1 | Frame alignment held |
| rx_frame_err | output | 1 | Sticky missing-pattern flag |
| tx_i0 | input | 12 | Channel 0 I sample to send |
| tx_q0 | input | 12 | Channel 0 Q sample to send |
| tx_i1 | input | 12 | Channel 1 I sample to send |
| tx_q1 | input | 12 | Channel 1 Q sample to send |
| tx_pull | output | 1 | Transmit samples captured this cycle |
| tx_rise_data | output | 12 | Transmit word for rising edge |
| tx_fall_data | output | 12 | Transmit word for falling edge |
| tx_frame_rise | output | 1 | FRAME for rising edge |
| tx_frame_fall | output | 1 | FRAME for falling edge |

## Verification
A received frame completes on the clock edge that captures its last edge pair. Its samples and `rx_valid` are therefore due at the falling edge that follows. The receive monitor samples only at falling edges and pops one expected frame per valid pulse. The lock and error flags react on the edge that ends the checked frame. Their checks are held back and made at the first falling edge of the next drive step, before new inputs are applied. On transmit, the first edge pair of a frame is due on the edge right after the falling edge where `tx_pull` is seen high. The transmit monitor rebuilds each frame from the FRAME history one falling edge at a time and compares it with the samples pushed when `tx_pull` was seen.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
    localparam int SMP_W  = 12;
    localparam int NSLOT  = 4;
    localparam int HALF_W = SMP_W / 2;
    localparam int EDGES  = 2 * NSLOT;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef logic [SMP_W-1:0] sample_t;
    typedef sample_t [NSLOT-1:0] frame_t;   // index NSLOT-1 holds the oldest sample (I0)

    localparam logic [EDGES-1:0] NARROW_PAT = {{NSLOT{1'b1}}, {NSLOT{1'b0}}};
    localparam logic [NSLOT-1:0] WIDE_PAT   = {{(NSLOT/2){1'b1}}, {(NSLOT/2){1'b0}}};
endpackage

// File: rtl/fdd_rx_deframer.sv
module fdd_rx_deframer
    import fdd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    narrow,
    input  sample_t rise,
    input  sample_t fall,
    input  logic    frm_r,
    input  logic    frm_f,
    output logic    valid,
    output frame_t  samples,
    output logic    locked,
    output logic    err
);
    typedef struct packed {
        logic [EDGES-1:0]  hist;
        frame_t            shift;
        logic [SLOT_W-1:0] phase;
        logic              locked;
        logic              err;
        logic              valid;
        frame_t            out;
    } rx_st_t;

    rx_st_t            rx_d, rx_q;
    logic              match;
    logic [SLOT_W-1:0] last;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.hist  = {rx_q.hist[EDGES-3:0], frm_r, frm_f};
        if (narrow) begin
            rx_d.shift = {rx_q.shift[NSLOT-2:0], rise[HALF_W-1:0], fall[HALF_W-1:0]};
            match      = (rx_d.hist == NARROW_PAT);
            last       = SLOT_W'(NSLOT - 1);
        end else begin
            rx_d.shift = {rx_q.shift[NSLOT-3:0], rise, fall};
            match      = (rx_d.hist[NSLOT-1:0] == WIDE_PAT);
            last       = SLOT_W'(NSLOT / 2 - 1);
        end
        rx_d.phase = rx_q.phase + 1'b1;
        if (match) begin
            rx_d.phase  = '0;
            rx_d.locked = 1'b1;
            rx_d.valid  = 1'b1;
            rx_d.out    = rx_d.shift;
        end else if (rx_q.locked && (rx_q.phase == last)) begin
            rx_d.locked = 1'b0;
            rx_d.err    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign valid   = rx_q.valid;
    assign samples = rx_q.out;
    assign locked  = rx_q.locked;
    assign err     = rx_q.err;
endmodule

// File: rtl/fdd_tx_framer.sv
module fdd_tx_framer
    import fdd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    narrow,
    input  frame_t  tx_in,
    output logic    pull,
    output sample_t rise,
    output sample_t fall,
    output logic    frm_r,
    output logic    frm_f
);
    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        frame_t            hold;
        sample_t           rise;
        sample_t           fall;
        logic              fr;
        logic              ff;
    } tx_st_t;

    tx_st_t            tx_d, tx_q;
    frame_t            src;
    logic [SLOT_W-1:0] idx_a, idx_b, last;
    logic [SLOT_W:0]   e0, e1;

    always_comb begin
        tx_d  = tx_q;
        pull  = (tx_q.cnt == '0);
        src   = pull ? tx_in : tx_q.hold;
        if (pull) tx_d.hold = tx_in;
        e0    = {tx_q.cnt, 1'b0};
        e1    = {tx_q.cnt, 1'b1};
        if (narrow) begin
            idx_a     = SLOT_W'(NSLOT - 1) - tx_q.cnt;
            idx_b     = idx_a;
            tx_d.rise = {{HALF_W{1'b0}}, src[idx_a][SMP_W-1:HALF_W]};
            tx_d.fall = {{HALF_W{1'b0}}, src[idx_a][HALF_W-1:0]};
            tx_d.fr   = (e0 < (SLOT_W+1)'(NSLOT));
            tx_d.ff   = (e1 < (SLOT_W+1)'(NSLOT));
            last      = SLOT_W'(NSLOT - 1);
        end else begin
            idx_a     = SLOT_W'(NSLOT - 1) - {tx_q.cnt[SLOT_W-2:0], 1'b0};
            idx_b     = idx_a - 1'b1;
            tx_d.rise = src[idx_a];
            tx_d.fall = src[idx_b];
            tx_d.fr   = (e0 < (SLOT_W+1)'(NSLOT / 2));
            tx_d.ff   = (e1 < (SLOT_W+1)'(NSLOT / 2));
            last      = SLOT_W'(NSLOT / 2 - 1);
        end
        tx_d.cnt = (tx_q.cnt == last) ? '0 : tx_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign rise  = tx_q.rise;
    assign fall  = tx_q.fall;
    assign frm_r = tx_q.fr;
    assign frm_f = tx_q.ff;
endmodule

// File: rtl/framed_ddr_deframer.sv
module framed_ddr_deframer
    import fdd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        narrow_mode,
    input  logic [11:0] rx_rise_data,
    input  logic [11:0] rx_fall_data,
    input  logic        rx_frame_rise,
    input  logic        rx_frame_fall,
    output logic        rx_valid,
    output logic [11:0] rx_i0,
    output logic [11:0] rx_q0,
    output logic [11:0] rx_i1,
    output logic [11:0] rx_q1,
    output logic        rx_locked,
    output logic        rx_frame_err,
    input  logic [11:0] tx_i0,
    input  logic [11:0] tx_q0,
    input  logic [11:0] tx_i1,
    input  logic [11:0] tx_q1,
    output logic        tx_pull,
    output logic [11:0] tx_rise_data,
    output logic [11:0] tx_fall_data,
    output logic        tx_frame_rise,
    output logic        tx_frame_fall
);
    frame_t rx_frame, tx_frame;

    assign tx_frame = {tx_i0, tx_q0, tx_i1, tx_q1};

    fdd_rx_deframer u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (narrow_mode),
        .rise    (rx_rise_data),
        .fall    (rx_fall_data),
        .frm_r   (rx_frame_rise),
        .frm_f   (rx_frame_fall),
        .valid   (rx_valid),
        .samples (rx_frame),
        .locked  (rx_locked),
        .err     (rx_frame_err)
    );

    assign rx_i0 = rx_frame[3];
    assign rx_q0 = rx_frame[2];
    assign rx_i1 = rx_frame[1];
    assign rx_q1 = rx_frame[0];

    fdd_tx_framer u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .narrow (narrow_mode),
        .tx_in  (tx_frame),
        .pull   (tx_pull),
        .rise   (tx_rise_data),
        .fall   (tx_fall_data),
        .frm_r  (tx_frame_rise),
        .frm_f  (tx_frame_fall)
    );
endmodule

// File: rtl/fdd_checker.sv
module fdd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        narrow_mode,
    input logic        rx_valid,
    input logic [11:0] rx_i0,
    input logic [11:0] rx_q0,
    input logic [11:0] rx_i1,
    input logic [11:0] rx_q1,
    input logic        rx_locked,
    input logic        rx_frame_err,
    input logic        tx_pull,
    input logic [11:0] tx_rise_data,
    input logic [11:0] tx_fall_data,
    input logic        tx_frame_rise,
    input logic        tx_frame_fall
);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_samples_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable({rx_i0, rx_q0, rx_i1, rx_q1}));

    assert_valid_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_locked);

    assert_unlock_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_locked) |-> rx_frame_err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> rx_frame_err);

    assert_pull_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pull |=> !tx_pull);

    assert_tx_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_mode |-> (tx_rise_data[11:6] == 6'd0 && tx_fall_data[11:6] == 6'd0));

    assert_tx_frame_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_rise == tx_frame_fall);
endmodule

bind framed_ddr_deframer fdd_checker u_chk (.*);

// File: tb/tb_framed_ddr_deframer.sv
`timescale 1ns/1ps
module tb_framed_ddr_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_mode = 1'b1;
    logic [11:0] rx_rise_data = '0, rx_fall_data = '0;
    logic        rx_frame_rise = 1'b0, rx_frame_fall = 1'b0;
    logic        rx_valid, rx_locked, rx_frame_err;
    logic [11:0] rx_i0, rx_q0, rx_i1, rx_q1;
    logic [11:0] tx_i0 = '0, tx_q0 = '0, tx_i1 = '0, tx_q1 = '0;
    logic        tx_pull, tx_frame_rise, tx_frame_fall;
    logic [11:0] tx_rise_data, tx_fall_data;

    always #5 clk = ~clk;

    framed_ddr_deframer dut (.*);

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [47:0] rxq[$];
    logic [47:0] txq[$];

    bit    chk_pending = 1'b0;
    logic  exp_lock, exp_err;
    string chk_tag;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one drive step: wait for the falling edge, settle any deferred flag check
    task automatic step();
        @(negedge clk);
        if (chk_pending) begin
            check({chk_tag, " rx_locked"}, 64'(rx_locked), 64'(exp_lock));
            check({chk_tag, " rx_frame_err"}, 64'(rx_frame_err), 64'(exp_err));
            chk_pending = 1'b0;
        end
    endtask

    task automatic expect_flags(input logic l, input logic e, input string tag);
        exp_lock = l; exp_err = e; chk_tag = tag; chk_pending = 1'b1;
    endtask

    task automatic rx_idle(input int n);
        for (int c = 0; c < n; c++) begin
            step();
            rx_rise_data  = 12'($urandom);
            rx_fall_data  = 12'($urandom);
            rx_frame_rise = 1'b0;
            rx_frame_fall = 1'b0;
        end
    endtask

    task automatic rx_frame(input bit good);
        logic [11:0] s[4];
        for (int k = 0; k < 4; k++) s[k] = 12'($urandom);
        if (narrow_mode) begin
            for (int k = 0; k < 4; k++) begin
                step();
                rx_rise_data  = {6'($urandom), s[k][11:6]};   // R11 junk in upper bits
                rx_fall_data  = {6'($urandom), s[k][5:0]};
                rx_frame_rise = good && (k < 2);
                rx_frame_fall = good && (k < 2);
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                step();
                rx_rise_data  = s[2*k];
                rx_fall_data  = s[2*k+1];
                rx_frame_rise = good && (k == 0);
                rx_frame_fall = good && (k == 0);
            end
        end
        if (good) rxq.push_back({s[0], s[1], s[2], s[3]});
    endtask

    task automatic set_tx();
        tx_i0 = 12'($urandom); tx_q0 = 12'($urandom);
        tx_i1 = 12'($urandom); tx_q1 = 12'($urandom);
        txq.push_back({tx_i0, tx_q0, tx_i1, tx_q1});
    endtask

    // receive monitor
    logic [47:0] rx_exp;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rxq.size() == 0) begin
                check("R6 rx_valid without a recognised frame", 64'(1), 64'(0));
            end else begin
                rx_exp = rxq.pop_front();
                check(narrow_mode ? "R4 R2 R11 rx frame" : "R4 R3 rx frame",
                      64'({rx_i0, rx_q0, rx_i1, rx_q1}), 64'(rx_exp));
            end
        end
    end

    // transmit monitor: rebuild frames from the edge history
    logic [7:0]  th;
    logic [11:0] tr[4];
    logic [11:0] tf[4];
    logic [47:0] tx_got, tx_exp;
    logic [5:0]  upper;
    always @(negedge clk) begin
        if (!rst_n) begin
            th = '0;
        end else begin
            th = {th[5:0], tx_frame_rise, tx_frame_fall};
            for (int k = 0; k < 3; k++) begin tr[k] = tr[k+1]; tf[k] = tf[k+1]; end
            tr[3] = tx_rise_data;
            tf[3] = tx_fall_data;
            if (narrow_mode && th == 8'b1111_0000 && txq.size() > 0) begin
                tx_exp = txq.pop_front();
                tx_got = {tr[0][5:0], tf[0][5:0], tr[1][5:0], tf[1][5:0],
                          tr[2][5:0], tf[2][5:0], tr[3][5:0], tf[3][5:0]};
                upper  = '0;
                for (int k = 0; k < 4; k++) upper = upper | tr[k][11:6] | tf[k][11:6];
                check("R9 tx narrow frame", 64'(tx_got), 64'(tx_exp));
                check("R9 tx narrow upper bits", 64'(upper), 64'(0));
            end else if (!narrow_mode && th[3:0] == 4'b1100 && txq.size() > 0) begin
                tx_exp = txq.pop_front();
                tx_got = {tr[2], tf[2], tr[3], tf[3]};
                check("R10 tx wide frame", 64'(tx_got), 64'(tx_exp));
            end
        end
    end

    task automatic run_mode(input bit nar);
        rst_n = 1'b0;
        @(negedge clk);
        narrow_mode   = nar;
        rx_rise_data  = '0; rx_fall_data = '0;
        rx_frame_rise = 1'b0; rx_frame_fall = 1'b0;
        set_tx();
        repeat (2) @(negedge clk);
        check("R1 rx_valid", 64'(rx_valid), 64'(0));
        check("R1 rx_locked", 64'(rx_locked), 64'(0));
        check("R1 rx_frame_err", 64'(rx_frame_err), 64'(0));
        check("R1 tx_pull", 64'(tx_pull), 64'(1));
        check("R1 tx outputs", 64'({tx_frame_rise, tx_frame_fall, tx_rise_data, tx_fall_data}), 64'(0));
        rst_n = 1'b1;
        fork
            begin
                rx_idle(3);
                expect_flags(1'b0, 1'b0, "R7 before lock");
                rx_frame(1'b1);
                rx_frame(1'b1);
                rx_frame(1'b1);
                expect_flags(1'b1, 1'b0, "R6 locked");
                rx_frame(1'b0);
                expect_flags(1'b0, 1'b1, "R6 missing pattern");
                rx_frame(1'b1);
                expect_flags(1'b1, 1'b1, "R7 sticky after relock");
                rx_frame(1'b1);
                rx_idle(4);
                expect_flags(1'b0, 1'b1, "R6 lost after idle");
                rx_idle(1);
            end
            begin
                for (int f = 0; f < 6; f++) begin
                    do @(negedge clk); while (!tx_pull);   // R8 capture cycle
                    set_tx();
                end
            end
        join
        repeat (12) @(negedge clk);
        check("R8 tx frames outstanding", 64'(txq.size()), 64'(0));
        check("R5 rx frames outstanding", 64'(rxq.size()), 64'(0));
    endtask

    initial begin
        run_mode(1'b1);
        run_mode(1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1-independent: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule